// File: doc/BRIEF.md
# SPI Slave Receiver with Halt Wake-up

This block receives serial bytes from an external SPI master and hands them to software through a data register, a set of status flags and an interrupt line. The serial clock, slave select and data input arrive asynchronously and are brought into the system clock domain through two-flop synchronizers. Frames use mode 0: data is sampled on the rising serial clock edge, most significant bit first, eight bits per frame.

The block also talks to a power manager. While the host is in a wait state the block simply keeps working, and its interrupt serves as the event that ends the wait. While the host is halted, software accesses are frozen, but a byte from the master is still received and latched. If the slave was selected when the halt began and interrupts are enabled, a wake-up request is raised. When the halt ends with slave mode still enabled, the block enters a recovery state. It leaves that state after one further complete frame, and that frame is discarded.

Top module: `spi_wake_slave`

## Requirements
- R1: After reset, rx_data is 0x00 and flag_done, flag_ovr, recovering, irq and wake are all 0.
- R2: While the slave is selected, eight rising sck_i edges shift in one byte, most significant bit first, sampling mosi_i. If flag_done was 0, the byte is loaded into rx_data and flag_done becomes 1.
- R3: The effective select is active when slave_en is 1 and the select level is 0. The select level comes from ss_soft_n when ss_soft_en is 1 and from ss_n_i otherwise. Clock edges while unselected are ignored, and deselecting the slave discards a partly received frame.
- R4: A byte completed while flag_done is already 1 sets flag_ovr. rx_data keeps the first unread byte and the new byte is discarded.
- R5: A pulse on data_rd clears flag_done and flag_ovr only if a pulse on stat_rd was seen while flag_done was 1 since the last clear. A data_rd pulse without that earlier status read changes nothing.
- R6: irq is a register that, one cycle later, equals flag_done AND irq_en. No separate wait-state input exists; the block runs unchanged in wait, and irq is the event that ends it.
- R7: While pwr_halt is 1, stat_rd and data_rd are ignored, so the flags cannot be cleared. A byte received during halt is still loaded and sets flag_done.
- R8: On the rising edge of pwr_halt, the effective select is latched. wake is a register that, one cycle later, equals pwr_halt AND the latched select AND flag_done AND irq_en. The latch is cleared when the halt ends.
- R9: When pwr_halt falls while slave_en is 1, recovering becomes 1. The next complete frame clears recovering, is not loaded into rx_data, and leaves the flags unchanged.
- R10: When pwr_halt falls while slave_en is 0, recovering stays 0. Clearing slave_en during recovery also clears recovering.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_i | input | 1 | Serial clock from master (asynchronous) |
| mosi_i | input | 1 | Serial data from master (asynchronous) |
| ss_n_i | input | 1 | External slave select, active low |
| slave_en | input | 1 | Slave mode enable |
| ss_soft_en | input | 1 | 1 selects the software select level instead of the pin |
| ss_soft_n | input | 1 | Software select level, active low |
| irq_en | input | 1 | Interrupt enable |
| pwr_halt | input | 1 | Host halt state from power manager |
| stat_rd | input | 1 | Status register read strobe |
| data_rd | input | 1 | Data register read strobe |
| rx_data | output | 8 | Received data register |
| flag_done | output | 1 | Transfer-complete flag |
| flag_ovr | output | 1 | Overrun flag |
| recovering | output | 1 | Recovery state after halt exit |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Wake-up request to power manager |

## Verification
Every byte value from 0x00 to 0xFF is shifted in and read back, so a bit-order or bit-drop error appears as a wrong value. Back-to-back frames without a clear separate the overrun path from normal loading, and a lone data read shows whether the status-then-data clear order is enforced. Frames sent under pin select, software select, deselected and with slave mode off show which select source governs, and a frame cut short by deselection checks the counter reset. Halt sequences entered with the slave selected and with it unselected, each left with slave mode on or off, tell apart wake-up, frozen reads, the discarded recovery frame and the immediate return to normal.

// File: rtl/spi_wake_pkg.sv
package spi_wake_pkg;
  localparam int unsigned FRAME_BITS_DEF = 8;
  localparam int unsigned SYNC_STAGES_DEF = 2;

  typedef struct packed {
    logic done;
    logic ovr;
  } rx_status_t;
endpackage

// File: rtl/spi_wake_sync.sv
module spi_wake_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] d_sync
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= RST_VAL;
          else     stage_q[s] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= RST_VAL;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign d_sync = stage_q[STAGES-1];
endmodule

// File: rtl/spi_wake_shifter.sv
module spi_wake_shifter #(
  parameter int unsigned FRAME_BITS = 8,
  localparam int unsigned CNT_W = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sel,
  input  logic                  sck_s,
  input  logic                  mosi_s,
  output logic                  frame_done,
  output logic [FRAME_BITS-1:0] frame_data
);
  logic                  sck_prev;
  logic [FRAME_BITS-1:0] shreg;
  logic [CNT_W-1:0]      bit_cnt;
  logic                  rise;

  assign rise       = sck_s & ~sck_prev;
  assign frame_done = sel & rise & (bit_cnt == CNT_W'(FRAME_BITS-1));
  assign frame_data = {shreg[FRAME_BITS-2:0], mosi_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_prev <= 1'b0;
      shreg    <= '0;
      bit_cnt  <= '0;
    end else begin
      sck_prev <= sck_s;
      if (!sel) begin
        bit_cnt <= '0;
      end else if (rise) begin
        shreg <= frame_data;
        if (bit_cnt == CNT_W'(FRAME_BITS-1)) bit_cnt <= '0;
        else                                  bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_wake_flags.sv
module spi_wake_flags
  import spi_wake_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  frame_done,
  input  logic [FRAME_BITS-1:0] frame_data,
  input  logic                  discard,
  input  logic                  halted,
  input  logic                  stat_rd,
  input  logic                  data_rd,
  output logic [FRAME_BITS-1:0] data_q,
  output rx_status_t            status
);
  logic armed_q;
  logic load;
  logic clr;

  assign load = frame_done & ~discard;
  assign clr  = data_rd & armed_q & ~halted;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      status  <= '{done: 1'b0, ovr: 1'b0};
      armed_q <= 1'b0;
    end else begin
      if (clr) begin
        armed_q    <= 1'b0;
        status.ovr <= 1'b0;
        if (load) begin
          data_q      <= frame_data;
          status.done <= 1'b1;
        end else begin
          status.done <= 1'b0;
        end
      end else begin
        if (stat_rd && status.done && !halted) armed_q <= 1'b1;
        if (load) begin
          if (status.done) begin
            status.ovr <= 1'b1;
          end else begin
            data_q      <= frame_data;
            status.done <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_wake_power.sv
module spi_wake_power (
  input  logic clk,
  input  logic rst,
  input  logic pwr_halt,
  input  logic slave_en,
  input  logic sel,
  input  logic frame_done,
  input  logic done,
  input  logic irq_en,
  output logic recovering,
  output logic irq,
  output logic wake
);
  logic halt_prev;
  logic sel_at_halt;
  logic halt_rise;
  logic halt_fall;

  assign halt_rise = pwr_halt & ~halt_prev;
  assign halt_fall = ~pwr_halt & halt_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      halt_prev   <= 1'b0;
      sel_at_halt <= 1'b0;
      recovering  <= 1'b0;
      irq         <= 1'b0;
      wake        <= 1'b0;
    end else begin
      halt_prev <= pwr_halt;
      irq       <= done & irq_en;
      wake      <= pwr_halt & sel_at_halt & done & irq_en;

      if (halt_rise)      sel_at_halt <= sel;
      else if (halt_fall) sel_at_halt <= 1'b0;

      if (halt_fall)
        recovering <= slave_en;
      else if (halt_rise || !slave_en || frame_done)
        recovering <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_wake_slave.sv
module spi_wake_slave
  import spi_wake_pkg::*;
#(
  parameter int unsigned FRAME_BITS  = FRAME_BITS_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sck_i,
  input  logic                  mosi_i,
  input  logic                  ss_n_i,
  input  logic                  slave_en,
  input  logic                  ss_soft_en,
  input  logic                  ss_soft_n,
  input  logic                  irq_en,
  input  logic                  pwr_halt,
  input  logic                  stat_rd,
  input  logic                  data_rd,
  output logic [FRAME_BITS-1:0] rx_data,
  output logic                  flag_done,
  output logic                  flag_ovr,
  output logic                  recovering,
  output logic                  irq,
  output logic                  wake
);
  localparam logic [2:0] SYNC_RST = 3'b100;

  logic [2:0]            pins_s;
  logic                  sck_s, mosi_s, ss_n_s;
  logic                  sel;
  logic                  frame_done;
  logic [FRAME_BITS-1:0] frame_data;
  rx_status_t            status;

  spi_wake_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst(rst),
    .d_async({ss_n_i, mosi_i, sck_i}),
    .d_sync(pins_s)
  );

  assign {ss_n_s, mosi_s, sck_s} = pins_s;
  assign sel = slave_en & ~(ss_soft_en ? ss_soft_n : ss_n_s);

  spi_wake_shifter #(.FRAME_BITS(FRAME_BITS)) u_shift (
    .clk(clk), .rst(rst), .sel(sel), .sck_s(sck_s), .mosi_s(mosi_s),
    .frame_done(frame_done), .frame_data(frame_data)
  );

  spi_wake_flags #(.FRAME_BITS(FRAME_BITS)) u_flags (
    .clk(clk), .rst(rst), .frame_done(frame_done), .frame_data(frame_data),
    .discard(recovering), .halted(pwr_halt), .stat_rd(stat_rd), .data_rd(data_rd),
    .data_q(rx_data), .status(status)
  );

  assign flag_done = status.done;
  assign flag_ovr  = status.ovr;

  spi_wake_power u_pwr (
    .clk(clk), .rst(rst), .pwr_halt(pwr_halt), .slave_en(slave_en), .sel(sel),
    .frame_done(frame_done), .done(status.done), .irq_en(irq_en),
    .recovering(recovering), .irq(irq), .wake(wake)
  );
endmodule

// File: rtl/spi_wake_chk.sv
module spi_wake_chk #(
  parameter int unsigned FRAME_BITS = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  pwr_halt,
  input logic                  irq_en,
  input logic [FRAME_BITS-1:0] rx_data,
  input logic                  flag_done,
  input logic                  flag_ovr,
  input logic                  recovering,
  input logic                  irq,
  input logic                  wake
);
  AST_OVR_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
    flag_ovr |-> flag_done); // R4
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
    (flag_done && $past(flag_done)) |-> $stable(rx_data)); // R4
  AST_IRQ_SET: assert property (@(posedge clk) disable iff (rst)
    (flag_done && irq_en) |=> irq); // R6
  AST_IRQ_CLR: assert property (@(posedge clk) disable iff (rst)
    !(flag_done && irq_en) |=> !irq); // R6
  AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (pwr_halt && $past(pwr_halt) && $past(flag_done)) |-> flag_done); // R7
  AST_WAKE_NEEDS_HALT: assert property (@(posedge clk) disable iff (rst)
    wake |-> ($past(pwr_halt) && irq)); // R8
  AST_RECOV_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
    $past(recovering) |-> $stable(rx_data)); // R9
endmodule

bind spi_wake_slave spi_wake_chk #(.FRAME_BITS(FRAME_BITS)) u_chk (
  .clk(clk), .rst(rst), .pwr_halt(pwr_halt), .irq_en(irq_en), .rx_data(rx_data),
  .flag_done(flag_done), .flag_ovr(flag_ovr), .recovering(recovering),
  .irq(irq), .wake(wake)
);

// File: tb/sim_spi_wake_slave.sv
`timescale 1ns/1ps
module sim_spi_wake_slave;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck_i = 1'b0, mosi_i = 1'b0, ss_n_i = 1'b1;
  logic slave_en = 1'b1, ss_soft_en = 1'b0, ss_soft_n = 1'b1, irq_en = 1'b1;
  logic pwr_halt = 1'b0, stat_rd = 1'b0, data_rd = 1'b0;
  logic [7:0] rx_data;
  logic flag_done, flag_ovr, recovering, irq, wake;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit ended  = 1'b0;

  always #5 clk = ~clk;

  spi_wake_slave u0 (
    .clk(clk), .rst(rst), .sck_i(sck_i), .mosi_i(mosi_i), .ss_n_i(ss_n_i),
    .slave_en(slave_en), .ss_soft_en(ss_soft_en), .ss_soft_n(ss_soft_n),
    .irq_en(irq_en), .pwr_halt(pwr_halt), .stat_rd(stat_rd), .data_rd(data_rd),
    .rx_data(rx_data), .flag_done(flag_done), .flag_ovr(flag_ovr),
    .recovering(recovering), .irq(irq), .wake(wake)
  );

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
      finish_run();
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic send_bits(input logic [7:0] v, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      mosi_i = v[i];
      wait_clk(4);
      sck_i = 1'b1;
      wait_clk(4);
      sck_i = 1'b0;
    end
    wait_clk(8);
  endtask

  task automatic send_byte(input logic [7:0] v);
    send_bits(v, 8);
  endtask

  task automatic sw_clear();
    stat_rd = 1'b1; wait_clk(1); stat_rd = 1'b0;
    data_rd = 1'b1; wait_clk(1); data_rd = 1'b0;
    wait_clk(2);
  endtask

  initial begin
    wait_clk(4);
    rst = 1'b0;
    wait_clk(2);
    // R1 reset state
    check("R1 data", rx_data, 0);
    check("R1 flags", {flag_done, flag_ovr, recovering, irq, wake}, 0);

    // R2 sweep of all byte values under pin select
    ss_n_i = 1'b0;
    wait_clk(4);
    for (int v = 0; v < 256; v++) begin
      send_byte(8'(v));
      check("R2 data", rx_data, 32'(v));
      check("R2 done/ovr", {flag_done, flag_ovr}, 2'b10);
      sw_clear();
      check("R5 cleared", {flag_done, flag_ovr}, 2'b00);
    end

    // R4 overrun keeps first byte; R5 lone data read does nothing
    send_byte(8'h12);
    send_byte(8'h34);
    check("R4 ovr", {flag_done, flag_ovr}, 2'b11);
    check("R4 data kept", rx_data, 8'h12);
    data_rd = 1'b1; wait_clk(1); data_rd = 1'b0; wait_clk(2);
    check("R5 lone data_rd", {flag_done, flag_ovr}, 2'b11);
    sw_clear();
    check("R5 clear both", {flag_done, flag_ovr}, 2'b00);

    // R6 irq follows done AND irq_en; no wait input exists
    irq_en = 1'b0;
    send_byte(8'h77);
    check("R6 irq masked", {flag_done, irq}, 2'b10);
    irq_en = 1'b1;
    wait_clk(2);
    check("R6 irq enabled", irq, 1);
    sw_clear();
    check("R6 irq drops", irq, 0);

    // R3 software select overrides pin
    ss_n_i = 1'b1; ss_soft_en = 1'b1; ss_soft_n = 1'b0;
    wait_clk(4);
    send_byte(8'h5A);
    check("R3 soft select rx", {flag_done, 8'(rx_data)}, {1'b1, 8'h5A});
    sw_clear();
    ss_soft_n = 1'b1; ss_n_i = 1'b0;
    wait_clk(4);
    send_byte(8'hFF);
    check("R3 soft deselect ignores", {flag_done, 8'(rx_data)}, {1'b0, 8'h5A});
    ss_soft_en = 1'b0; slave_en = 1'b0;
    wait_clk(4);
    send_byte(8'hC3);
    check("R3 slave off ignores", {flag_done, 8'(rx_data)}, {1'b0, 8'h5A});
    slave_en = 1'b1;
    wait_clk(4);
    send_bits(8'hFF, 5);
    ss_n_i = 1'b1; wait_clk(6); ss_n_i = 1'b0; wait_clk(6);
    send_byte(8'h81);
    check("R3 partial frame dropped", {flag_done, 8'(rx_data)}, {1'b1, 8'h81});
    sw_clear();

    // R8/R7/R9 halt entered while selected
    pwr_halt = 1'b1;
    wait_clk(4);
    check("R8 no wake before rx", wake, 0);
    send_byte(8'hA5);
    check("R7 rx in halt", {flag_done, 8'(rx_data)}, {1'b1, 8'hA5});
    check("R8 wake", wake, 1);
    sw_clear();
    check("R7 reads frozen", flag_done, 1);
    pwr_halt = 1'b0;
    wait_clk(3);
    check("R9 recovering set", recovering, 1);
    check("R8 wake drops", wake, 0);
    sw_clear();
    check("R9 clear after wake", flag_done, 0);
    send_byte(8'h3C);
    check("R9 recovery frame discarded", {recovering, flag_done, 8'(rx_data)}, {2'b00, 8'hA5});
    send_byte(8'h3C);
    check("R9 normal after recovery", {flag_done, 8'(rx_data)}, {1'b1, 8'h3C});
    sw_clear();

    // R8 halt entered while unselected: no wake; R10 exit with slave off
    ss_n_i = 1'b1;
    wait_clk(4);
    pwr_halt = 1'b1;
    wait_clk(4);
    ss_n_i = 1'b0;
    wait_clk(4);
    send_byte(8'h69);
    check("R8 unselected at halt", {flag_done, irq, wake}, 3'b110);
    slave_en = 1'b0;
    wait_clk(1);
    pwr_halt = 1'b0;
    wait_clk(3);
    check("R10 no recovery", recovering, 0);
    slave_en = 1'b1;
    wait_clk(3);
    check("R10 still normal", recovering, 0);
    sw_clear();
    send_byte(8'h96);
    check("R10 frame loads", {flag_done, 8'(rx_data)}, {1'b1, 8'h96});
    sw_clear();

    // R10 clearing slave_en during recovery ends it
    pwr_halt = 1'b1; wait_clk(4); pwr_halt = 1'b0; wait_clk(3);
    check("R9 recovering again", recovering, 1);
    slave_en = 1'b0; wait_clk(3);
    check("R10 slave off ends recovery", recovering, 0);

    finish_run();
  end
endmodule